// File: doc/BRIEF.md
# Exchange-Only Word Store with a Live Working Register

This block is a small word memory that has no read strobe and no write strobe. One word at a time is held outside the array in a working register. That word is called the checked-out word. The user sees it directly on `work_rd`. The user edits it in place through a per-bit write port: each enable bit lets the matching data bit through. While a word is checked out, its own array slot holds zero.

The only storage operation is an exchange between the working register and one array slot, and it takes one cycle. When `addr_in` settles on a new value, the block runs two exchanges in two separate, consecutive cycles. First it returns the working register into the slot it came from, which brings that slot's zero back into the register. Then it exchanges the now-empty register with the slot at the new address. `busy` is high while the exchanges run. Writes made while `busy` is high are ignored. An address that arrives during a sequence is only picked up after the sequence ends, so no more than one word is ever outside the array.

After reset the block sweeps zero through every slot, one slot per cycle, holding `busy` high while it does so. It then checks out address 0 with a zero working register.

Top module: `swap_word_mem`

## Requirements
- R1: After the synchronous reset is released, `busy` stays high for exactly DEPTH cycles while every slot is cleared. It then drops with `work_rd` = 0, and every address later checks out as zero.
- R2: While `busy` is low, on each clock edge bit i of the working register takes `wr_data[i]` wherever `wr_en[i]` = 1, and every other bit keeps its value. The result is visible on `work_rd` after that edge.
- R3: If `addr_in` presented at an idle edge k differs from the checked-out address, `busy` is low after edge k, high after edges k+1 and k+2, and low again after edge k+3. At that point `work_rd` shows the word stored at the new address.
- R4: Edits made to a checked-out word are kept when it is returned and reappear when that address is checked out again. This holds for any bit pattern, including all ones and alternating bits.
- R5: The return exchange happens in the cycle before the fetch exchange, never in the same cycle or after it. Between the two, `work_rd` reads 0, which is the content of the emptied slot.
- R6: The slot of the checked-out word holds zero, so each stored word exists in exactly one place: a slot or the working register.
- R7: Write enables applied while `busy` is high do not change any word.
- R8: An `addr_in` change made while `busy` is high is not sampled until the first edge after `busy` falls. The sequence in progress completes to the previously sampled address first, and a second sequence then fetches the later address.
- R9: If `addr_in` equals the checked-out address, no exchange occurs and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W (6) | Address of the word to check out |
| wr_en | input | DATA_W (16) | Per-bit write enable into the working register |
| wr_data | input | DATA_W (16) | Per-bit write data |
| work_rd | output | DATA_W (16) | Current content of the working register |
| busy | output | 1 | High during the reset clear sweep and the exchange sequence |

## Verification
The bench builds the block with its default parameters: 16-bit words and a 6-bit address, which gives 64 slots. With 64 slots the full reset sweep is short enough to be timed cycle by cycle, both ends of the address range (0 and 63) can be reached directly, and random checkouts revisit addresses often enough that edited words come back through many return-and-fetch round trips. The 16-bit width allows all-ones, alternating and single-bit patterns, so the exchanges can be shown to behave the same whatever the data.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    PH_CLEAR  = 2'd0,
    PH_IDLE   = 2'd1,
    PH_RETURN = 2'd2,
    PH_FETCH  = 2'd3
  } phase_t;
endpackage

// File: rtl/swm_store.sv
module swm_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  // single write port plus registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
    rdata <= slots[raddr];
  end
endmodule

// File: rtl/swm_seq.sv
module swm_seq
  import swm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  output phase_t            phase,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [ADDR_W-1:0] clr_idx,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CLEAR;
      clr_idx  <= '0;
      cur_addr <= '0;
      tgt_addr <= '0;
    end else begin
      unique case (phase)
        PH_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST) phase <= PH_IDLE;
        end
        PH_IDLE: begin
          if (tgt_addr != cur_addr) phase <= PH_RETURN;
          else                      tgt_addr <= addr_in;
        end
        PH_RETURN: phase <= PH_FETCH;
        PH_FETCH: begin
          cur_addr <= tgt_addr;
          phase    <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);

  // return is followed by fetch in the very next cycle
  assert_return_then_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RETURN) |=> (phase == PH_FETCH));
  // fetch is only ever entered from a return
  assert_fetch_after_return_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |-> ($past(phase) == PH_RETURN));
  // the sampled target is frozen while a sequence or sweep runs
  assert_target_held_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tgt_addr));
  // the sweep does not end early
  assert_sweep_continues_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLEAR && clr_idx != LAST) |=> (phase == PH_CLEAR));
endmodule

// File: rtl/swm_work.sv
module swm_work #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_wr,
  input  logic              load_zero,
  input  logic              load_fetch,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic [DATA_W-1:0] wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] work_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                         work_q[i] <= 1'b0;
      else if (load_fetch)             work_q[i] <= fetch_data[i];
      else if (load_zero)              work_q[i] <= 1'b0;
      else if (accept_wr && wr_en[i])  work_q[i] <= wr_data[i];
    end
  end

  // with no exchange and writes refused, the word must not move
  assert_refused_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!accept_wr && !load_zero && !load_fetch) |=> $stable(work_q));
endmodule

// File: rtl/swap_word_mem.sv
module swap_word_mem
  import swm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] work_rd,
  output logic              busy
);
  phase_t            phase;
  logic [ADDR_W-1:0] cur_addr, tgt_addr, clr_idx;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, work_q;

  swm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in), .phase(phase),
    .cur_addr(cur_addr), .tgt_addr(tgt_addr), .clr_idx(clr_idx), .busy(busy)
  );

  // both exchanges write the live register; the sweep writes zero
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = cur_addr;
    mem_wdata = work_q;
    unique case (phase)
      PH_CLEAR:  begin mem_we = 1'b1; mem_waddr = clr_idx; mem_wdata = '0; end
      PH_RETURN: begin mem_we = 1'b1; mem_waddr = cur_addr; end
      PH_FETCH:  begin mem_we = 1'b1; mem_waddr = tgt_addr; end
      default:   mem_we = 1'b0;
    endcase
  end

  swm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(tgt_addr), .rdata(mem_rdata)
  );

  swm_work #(.DATA_W(DATA_W)) u_work (
    .clk(clk), .rst(rst),
    .accept_wr(!busy),
    .load_zero(phase == PH_RETURN),
    .load_fetch(phase == PH_FETCH),
    .fetch_data(mem_rdata),
    .wr_en(wr_en), .wr_data(wr_data), .work_q(work_q)
  );

  assign work_rd = work_q;

  // the register is empty when exchanged into the new slot
  assert_empty_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |-> (work_q == '0));
  // return and prefetch never touch the same slot in one cycle
  assert_distinct_slots_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RETURN) |-> (cur_addr != tgt_addr));
  // matching address starts nothing
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && tgt_addr == cur_addr) |=> (phase == PH_IDLE));
endmodule

// File: tb/tb_swap_word_mem.sv
module tb_swap_word_mem;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wr_en = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] work_rd;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] ref_cur;

  always #10 clk = ~clk;

  swap_word_mem #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .wr_en(wr_en),
    .wr_data(wr_data), .work_rd(work_rd), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // full timed checkout of address a (a differs from the current one)
  task automatic checkout(input logic [AW-1:0] a, input string tag);
    addr_in = a;
    step();
    chk("R3 busy low after sampling edge", 32'(busy), 0);
    step();
    chk("R3 busy high first exchange", 32'(busy), 1);
    step();
    chk("R3 busy high second exchange", 32'(busy), 1);
    chk("R5 register empty between exchanges", 32'(work_rd), 0);
    step();
    chk("R3 busy low after fetch", 32'(busy), 0);
    chk(tag, 32'(work_rd), 32'(ref_mem[a]));
    ref_cur = a;
  endtask

  task automatic write_bits(input logic [DW-1:0] en, input logic [DW-1:0] d);
    wr_en = en;
    wr_data = d;
    step();
    wr_en = '0;
    ref_mem[ref_cur] = (ref_mem[ref_cur] & ~en) | (d & en);
    chk("R2 per-bit write", 32'(work_rd), 32'(ref_mem[ref_cur]));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20 && busy; i++) step();
  endtask

  task automatic t_reset();
    int n;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    ref_cur = '0;
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      step();
      n++;
    end
    chk("R1 sweep length", 32'(n), 32'(DEPTH));
    chk("R1 register zero after reset", 32'(work_rd), 0);
    checkout(6'd63, "R1 top slot cleared");
    checkout(6'd5, "R1 middle slot cleared");
    checkout(6'd0, "R1 slot zero cleared");
  endtask

  task automatic t_bits();
    write_bits(16'hFFFF, 16'hA5A5);
    write_bits(16'h00F0, 16'h0000);
    write_bits(16'h8001, 16'hFFFF);
  endtask

  task automatic t_roundtrip();
    checkout(6'd10, "R4 fresh slot");
    write_bits(16'hFFFF, 16'hFFFF);
    checkout(6'd11, "R4 neighbour untouched");
    write_bits(16'hFFFF, 16'h5555);
    checkout(6'd10, "R4 all-ones word returned");
    checkout(6'd11, "R4 alternating word returned");
    checkout(6'd0, "R4 edited slot zero kept");
  endtask

  task automatic t_busy_write();
    logic [AW-1:0] old;
    old = ref_cur;
    addr_in = 6'd20;
    step();
    step();
    chk("R7 busy before blocked write", 32'(busy), 1);
    wr_en = 16'hFFFF;
    wr_data = 16'h1234;
    step();
    step();
    wr_en = '0;
    chk("R7 new word unchanged", 32'(work_rd), 32'(ref_mem[20]));
    ref_cur = 6'd20;
    checkout(old, "R7 old word unchanged");
  endtask

  task automatic t_deferred();
    addr_in = 6'd30;
    step();
    step();
    chk("R8 sequence running", 32'(busy), 1);
    addr_in = 6'd31;
    step();
    step();
    chk("R8 first sequence done", 32'(busy), 0);
    chk("R8 earlier address fetched", 32'(work_rd), 32'(ref_mem[30]));
    ref_cur = 6'd30;
    step();
    chk("R8 later address sampled only now", 32'(busy), 0);
    step();
    chk("R8 second sequence started", 32'(busy), 1);
    wait_idle();
    chk("R8 later address fetched", 32'(work_rd), 32'(ref_mem[31]));
    ref_cur = 6'd31;
  endtask

  task automatic t_same();
    addr_in = ref_cur;
    write_bits(16'h0F0F, 16'h0303);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 no exchange on same address", 32'(busy), 0);
    end
    chk("R9 word kept", 32'(work_rd), 32'(ref_mem[ref_cur]));
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % DEPTH);
      if (a != ref_cur) checkout(a, "R6 word found in one place only");
      write_bits(DW'($urandom), DW'($urandom));
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bits();
    t_roundtrip();
    t_busy_write();
    t_deferred();
    t_same();
    t_random();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule